// File: doc/BRIEF.md
# Packet-Holding Three-Way Merge Switch with Path Locking

This block merges three cell streams onto a single output in a request network. A packet is a run of cells that ends with a cell flagged as last. Each input also carries two sideband fields that come from the packet header: a pressure value, which sets service priority, and a packet kind. While the output is idle, the switch spends one cycle choosing a winner among the inputs that show a valid header cell. The winner then keeps the output until its last cell has been accepted, so cells from different packets never interleave on the output.

The winner is the input with the highest pressure. When several inputs share that pressure, the choice rotates, starting with the input after the one granted most recently. A packet of kind "lock" reserves the output for its sender. From then on only that sender can win, whatever the pressures of the other inputs. The reservation ends when an "unlock" packet from the same sender finishes. This lets an initiator carry out an atomic read-modify-write across the network. The output's back-pressure is passed only to the granted input. Every other input sees ready held low.

Top module: `wh_switch`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid and every in_ready are low and no lock is held. After reset, the first tie among equal pressures is won by input 0.
- R2: In an idle cycle, the eligible input with the largest unsigned in_press value is granted. Its cells appear on the output from the next cycle, and out_src gives its index.
- R3: When several eligible inputs share the largest pressure, the grant goes to the first of them, counting upward with wrap-around, after the input granted most recently.
- R4: Once an input is granted, only its cells appear on the output, in order, up to and including its last cell. out_src stays constant for the whole packet, and every cell that is offered is delivered.
- R5: In the cycle after the output accepts a last cell, out_valid and all in_ready are low and the switch arbitrates. The new winner is served from the cycle after that.
- R6: in_ready of the granted input equals out_ready. in_ready of every other input is low.
- R7: A packet whose header kind is 2'b01 (lock) reserves the output. Until an unlock packet (kind 2'b10) from the same input has had its last cell accepted, no other input is granted.
- R8: While the output is reserved, the locking input is granted even when waiting inputs have higher pressure. Its packets of kind 2'b00 do not release the reservation.
- R9: A kind 2'b10 packet sent while no lock is held, and any kind 2'b11 packet, behaves as an ordinary packet and reserves nothing.
- R10: While a packet is being served, out_valid, out_data and out_last follow in_valid, in_data and in_last of the granted input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | N | Per-input cell valid |
| in_ready | output | N | Per-input cell accept |
| in_data | input | N x DW | Per-input cell payload |
| in_last | input | N | Per-input last-cell-of-packet flag |
| in_press | input | N x PW | Per-input header pressure, larger is more urgent |
| in_kind | input | N x 2 | Per-input header kind: 00 plain, 01 lock, 10 unlock, 11 plain |
| out_valid | output | 1 | Output cell valid |
| out_ready | input | 1 | Output cell accept |
| out_data | output | DW | Output cell payload |
| out_last | output | 1 | Output last-cell flag |
| out_src | output | IW | Index of the granted input |

## Verification
The hardest case to reach is a lock held while the other inputs wait with higher pressure, followed by an unlock that has to hand the output back to the normal pressure-and-rotation order. Random traffic seldom reaches this case. The stimulus therefore enables only the locking input for the cycle in which it wins, then opens the other inputs with maximum pressure while the locking input sends a plain packet and then its unlock. A separate sequence sends an unlock with no lock held and queues the sender's next packet at the lowest pressure, so a reservation created by mistake would show up as the wrong grant. A sweep over every pressure combination and long random runs with locks, gaps and stalls cover the rest.

// File: rtl/wh_pkg.sv
// Shared definitions for the packet-holding merge switch.
package wh_pkg;
    // Header kind carried beside every cell; only the value at grant time matters.
    typedef enum logic [1:0] {
        PKT_PLAIN  = 2'b00,
        PKT_LOCK   = 2'b01,
        PKT_UNLOCK = 2'b10,
        PKT_SPARE  = 2'b11
    } pkt_kind_e;
endpackage

// File: rtl/wh_arbiter.sv
// Pressure-first arbiter with rotating tie-break.
// Picks the requester with the largest pressure. Among equal pressures it
// scans upward from the input after last_idx. Assumes last_idx < N.
module wh_arbiter #(
    parameter  int N  = 3,
    parameter  int PW = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][PW-1:0] press,
    input  logic [IW-1:0]        last_idx,
    output logic                 any,
    output logic [IW-1:0]        win
);
    // Finds the top pressure, then the first matching requester after last_idx.
    always_comb begin
        logic [PW-1:0] top_p;
        logic          found;
        logic [IW:0]   cand;
        top_p = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (press[i] > top_p)) top_p = press[i];
        end
        found = 1'b0;
        win   = '0;
        for (int k = 1; k <= N; k++) begin
            cand = {1'b0, last_idx} + (IW+1)'(k);
            if (cand >= (IW+1)'(N)) cand = cand - (IW+1)'(N);
            if (!found && req[cand[IW-1:0]] && (press[cand[IW-1:0]] == top_p)) begin
                found = 1'b1;
                win   = cand[IW-1:0];
            end
        end
        any = |req;
    end
endmodule

// File: rtl/wh_lock_ctl.sv
// Path reservation state.
// Sets a reservation when a lock packet is granted and clears it when the
// reserving input's unlock packet delivers its last cell. Assumes grant and
// end-of-packet never coincide, since grants occur only while idle.
module wh_lock_ctl #(
    parameter  int N  = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grant_fire,
    input  logic [IW-1:0] grant_idx,
    input  logic [1:0]    grant_kind,
    input  logic          eop_fire,
    input  logic [1:0]    pkt_kind,
    output logic          lock_on,
    output logic [IW-1:0] lock_idx
);
    import wh_pkg::*;

    // Tracks which input, if any, holds the output reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_on  <= 1'b0;
            lock_idx <= '0;
        end else if (grant_fire && (grant_kind == PKT_LOCK)) begin
            lock_on  <= 1'b1;
            lock_idx <= grant_idx;
        end else if (eop_fire && lock_on && (pkt_kind == PKT_UNLOCK)) begin
            lock_on  <= 1'b0;
        end
    end
endmodule

// File: rtl/wh_cell_mux.sv
// Output steering and ready fan-out.
// Forwards the owner's cell to the output and passes out_ready back to the
// owner only. Assumes owner < N whenever busy is high.
module wh_cell_mux #(
    parameter  int N  = 3,
    parameter  int DW = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 busy,
    input  logic [IW-1:0]        owner,
    input  logic [N-1:0]         in_valid,
    input  logic [N-1:0][DW-1:0] in_data,
    input  logic [N-1:0]         in_last,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [DW-1:0]        out_data,
    output logic                 out_last,
    output logic [N-1:0]         in_ready
);
    // One ready gate per input: only the owner sees output back-pressure.
    for (genvar g = 0; g < N; g++) begin : g_ready
        assign in_ready[g] = busy && (owner == IW'(g)) && out_ready;
    end

    // Output cell comes straight from the owner while a packet is held.
    assign out_valid = busy && in_valid[owner];
    assign out_data  = in_data[owner];
    assign out_last  = busy && in_last[owner];
endmodule

// File: rtl/wh_switch.sv
// Packet-holding N-to-1 merge switch with path locking.
// Spends one idle cycle choosing a winner, then holds the output for that
// input until its last cell is accepted. A lock packet narrows eligibility to
// the locking input until its unlock packet completes. Assumes the header
// sideband (in_press, in_kind) is valid together with each header cell.
module wh_switch #(
    parameter  int N  = 3,
    parameter  int DW = 16,
    parameter  int PW = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         in_valid,
    output logic [N-1:0]         in_ready,
    input  logic [N-1:0][DW-1:0] in_data,
    input  logic [N-1:0]         in_last,
    input  logic [N-1:0][PW-1:0] in_press,
    input  logic [N-1:0][1:0]    in_kind,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [DW-1:0]        out_data,
    output logic                 out_last,
    output logic [IW-1:0]        out_src
);
    import wh_pkg::*;

    logic          busy;
    logic [IW-1:0] owner;
    logic [1:0]    own_kind;
    logic [IW-1:0] last_srv;
    logic [N-1:0]  elig;
    logic          arb_any;
    logic [IW-1:0] arb_win;
    logic          grant_fire;
    logic          eop_fire;
    logic          lock_on;
    logic [IW-1:0] lock_idx;

    // Eligibility: every valid input, or only the lock holder while reserved.
    for (genvar g = 0; g < N; g++) begin : g_elig
        assign elig[g] = in_valid[g] && (!lock_on || (lock_idx == IW'(g)));
    end

    wh_arbiter #(.N(N), .PW(PW)) u_arb (
        .req      (elig),
        .press    (in_press),
        .last_idx (last_srv),
        .any      (arb_any),
        .win      (arb_win)
    );

    assign grant_fire = !busy && arb_any;
    assign eop_fire   = busy && out_valid && out_ready && out_last;

    // Ownership register: set on grant, dropped after the last cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            owner    <= '0;
            own_kind <= PKT_PLAIN;
            last_srv <= IW'(N - 1);
        end else if (grant_fire) begin
            busy     <= 1'b1;
            owner    <= arb_win;
            own_kind <= in_kind[arb_win];
            last_srv <= arb_win;
        end else if (eop_fire) begin
            busy     <= 1'b0;
        end
    end

    wh_lock_ctl #(.N(N)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_fire (grant_fire),
        .grant_idx  (arb_win),
        .grant_kind (in_kind[arb_win]),
        .eop_fire   (eop_fire),
        .pkt_kind   (own_kind),
        .lock_on    (lock_on),
        .lock_idx   (lock_idx)
    );

    wh_cell_mux #(.N(N), .DW(DW)) u_mux (
        .busy      (busy),
        .owner     (owner),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .in_ready  (in_ready)
    );

    assign out_src = owner;
endmodule

// File: rtl/wh_switch_chk.sv
// Property checker for wh_switch, attached by bind below.
// Observes ports plus the reservation state from the lock controller.
module wh_switch_chk #(
    parameter  int N  = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  in_valid,
    input logic [N-1:0]  in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic          out_last,
    input logic [IW-1:0] out_src,
    input logic          lock_on,
    input logic [IW-1:0] lock_idx
);
    // R6: at most one input is offered acceptance.
    p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    // R6: acceptance at an input only when the output accepts.
    p_ready_needs_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|in_ready) |-> out_ready);

    // R4: source index stays put inside a packet.
    p_src_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_src == $past(out_src)));

    // R5: the cycle after a delivered last cell is idle.
    p_gap_after_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && (in_ready == '0)));

    // R7: while reserved, the output only carries the lock holder.
    p_lock_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_on && out_valid) |-> (out_src == lock_idx));

    // R7: a reservation survives until some packet ends.
    p_lock_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_on && !(out_valid && out_ready && out_last)) |=> (lock_on && $stable(lock_idx)));

    // R10: a valid output cell is backed by a valid input cell of the owner.
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid[out_src]);
endmodule

bind wh_switch wh_switch_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .out_src   (out_src),
    .lock_on   (lock_on),
    .lock_idx  (lock_idx)
);

// File: tb/wh_switch_bench.sv
`timescale 1ns/1ps
// Self-checking bench: pressure sweep, directed lock cases, random traffic.
module wh_switch_bench;
    localparam int N    = 3;
    localparam int DW   = 16;
    localparam int PW   = 2;
    localparam int IW   = 2;
    localparam int QMAX = 48;
    localparam int WDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]         in_valid = '0;
    logic [N-1:0]         in_ready;
    logic [N-1:0][DW-1:0] in_data = '0;
    logic [N-1:0]         in_last = '0;
    logic [N-1:0][PW-1:0] in_press = '0;
    logic [N-1:0][1:0]    in_kind = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic [DW-1:0]        out_data;
    logic                 out_last;
    logic [IW-1:0]        out_src;

    wh_switch #(.N(N), .DW(DW), .PW(PW)) u_wh_switch (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_press(in_press), .in_kind(in_kind),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_src(out_src)
    );

    int checks = 0, errors = 0, cycles = 0;
    bit abort = 0;

    int q_len[N][QMAX];
    int q_press[N][QMAX];
    int q_kind[N][QMAX];
    int q_cnt[N], cur_pkt[N], cur_cell[N], exp_cells[N], got_cells[N];
    bit src_en[N];
    int vprob = 100, rprob = 100;

    // Reference state derived from the requirements.
    bit    m_busy = 0, m_locked = 0, m_new = 0, stray = 0, first_grant = 1;
    int    m_owner = 0, m_last = N - 1, m_lock = 0, m_kind = 0;
    string m_tag = "R2";

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word(int s, int p, int c);
        return {2'(s), 6'(p), 8'(c)};
    endfunction

    task automatic clear_q();
        for (int i = 0; i < N; i++) begin
            q_cnt[i] = 0; cur_pkt[i] = 0; cur_cell[i] = 0;
            exp_cells[i] = 0; got_cells[i] = 0; src_en[i] = 1;
        end
    endtask

    task automatic add_pkt(int s, int len, int p, int k);
        q_len[s][q_cnt[s]] = len; q_press[s][q_cnt[s]] = p; q_kind[s][q_cnt[s]] = k;
        exp_cells[s] += len; q_cnt[s]++;
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            if (src_en[i] && cur_pkt[i] < q_cnt[i] && int'($urandom % 100) < vprob) begin
                in_valid[i] = 1'b1;
                in_data[i]  = word(i, cur_pkt[i], cur_cell[i]);
                in_last[i]  = (cur_cell[i] == q_len[i][cur_pkt[i]] - 1);
                in_press[i] = PW'(q_press[i][cur_pkt[i]]);
                in_kind[i]  = 2'(q_kind[i][cur_pkt[i]]);
            end else begin
                in_valid[i] = 1'b0; in_data[i] = '0; in_last[i] = 1'b0;
                in_press[i] = '0;   in_kind[i] = '0;
            end
        end
        out_ready = (int'($urandom % 100) < rprob);
    endtask

    task automatic step();
        @(negedge clk);
        drive();
        #1;
        cycles++;
        if (cycles > WDOG && !abort) begin
            abort = 1; errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WDOG);
        end
        if (!m_busy) begin
            int top, ties, win, hi_other;
            bit any;
            check(!out_valid && in_ready == '0, "R5", "idle cycle outputs", {out_valid, in_ready}, 0);
            top = 0; ties = 0; any = 0; win = 0; hi_other = 0;
            for (int i = 0; i < N; i++)
                if (in_valid[i] && (!m_locked || i == m_lock)) begin
                    any = 1; if (int'(in_press[i]) > top) top = int'(in_press[i]);
                end
            for (int i = 0; i < N; i++) begin
                if (in_valid[i] && (!m_locked || i == m_lock) && int'(in_press[i]) == top) ties++;
                if (in_valid[i] && m_locked && i != m_lock && int'(in_press[i]) > top) hi_other = 1;
            end
            for (int k = N; k >= 1; k--) begin
                int c;
                c = (m_last + k) % N;
                if (in_valid[c] && (!m_locked || c == m_lock) && int'(in_press[c]) == top) win = c;
            end
            if (any) begin
                if (first_grant)   m_tag = "R1";
                else if (m_locked) m_tag = hi_other ? "R8" : "R7";
                else if (stray)    m_tag = "R9";
                else if (ties > 1) m_tag = "R3";
                else               m_tag = "R2";
                first_grant = 0; stray = 0;
                m_busy = 1; m_owner = win; m_last = win; m_new = 1;
                m_kind = int'(in_kind[win]);
                if (m_kind == 1) begin m_locked = 1; m_lock = win; end
                else if (m_kind == 3 || (m_kind == 2 && !m_locked)) stray = 1;
            end
        end else begin
            if (m_new) begin
                check(int'(out_src) == m_owner, m_tag, "granted input", out_src, m_owner);
                m_new = 0;
            end
            check(int'(out_src) == m_owner, "R4", "source held", out_src, m_owner);
            check(in_ready == (out_ready ? 3'(1 << m_owner) : 3'b0), "R6", "ready fan-out",
                  in_ready, out_ready ? (1 << m_owner) : 0);
            check(out_valid == in_valid[m_owner], "R10", "valid follows owner", out_valid, in_valid[m_owner]);
            if (in_valid[m_owner]) begin
                check(out_data == word(m_owner, cur_pkt[m_owner], cur_cell[m_owner]), "R4",
                      "cell order", out_data, word(m_owner, cur_pkt[m_owner], cur_cell[m_owner]));
                check(out_data == in_data[m_owner] && out_last == in_last[m_owner], "R10",
                      "data follows owner", out_data, in_data[m_owner]);
            end
            if (m_locked)
                check(int'(out_src) == m_lock, "R7", "reserved output", out_src, m_lock);
            if (in_valid[m_owner] && out_ready) begin
                got_cells[m_owner]++;
                if (in_last[m_owner]) begin
                    cur_pkt[m_owner]++; cur_cell[m_owner] = 0; m_busy = 0;
                    if (m_kind == 2 && m_locked) m_locked = 0;
                end else begin
                    cur_cell[m_owner]++;
                end
            end
        end
    endtask

    task automatic run_drain();
        bit pend;
        pend = 1;
        while (!abort && (pend || m_busy)) begin
            step();
            pend = 0;
            for (int i = 0; i < N; i++) if (cur_pkt[i] < q_cnt[i]) pend = 1;
        end
        for (int i = 0; i < N; i++)
            check(got_cells[i] == exp_cells[i], "R4", "cells delivered", got_cells[i], exp_cells[i]);
    endtask

    initial begin
        clear_q();
        // R1: outputs quiet during reset even with every input valid.
        in_valid = '1; in_last = '1; out_ready = 1'b1;
        for (int r = 0; r < 3; r++) begin
            @(negedge clk); #1;
            check(!out_valid && in_ready == '0, "R1", "reset outputs", {out_valid, in_ready}, 0);
        end
        @(negedge clk); in_valid = '0; in_last = '0; rst_n = 1'b1;
        #1;
        check(!out_valid && in_ready == '0, "R1", "first cycle after reset", {out_valid, in_ready}, 0);

        // R2 R3: every pressure combination, one packet per input.
        for (int code = 0; code < 64 && !abort; code++) begin
            clear_q();
            rprob = (code % 2 == 0) ? 100 : 60;
            vprob = 100;
            for (int i = 0; i < N; i++) add_pkt(i, 1 + (code + i) % 3, (code >> (2 * i)) & 3, 0);
            run_drain();
        end

        // R7 R8: input 0 locks at low pressure, others wait at top pressure.
        clear_q(); rprob = 80; vprob = 100;
        add_pkt(0, 2, 0, 1); add_pkt(0, 1, 0, 0); add_pkt(0, 2, 0, 2);
        add_pkt(1, 2, 3, 0); add_pkt(1, 1, 3, 0);
        add_pkt(2, 2, 3, 0); add_pkt(2, 1, 3, 0);
        src_en[1] = 0; src_en[2] = 0;
        step();
        src_en[1] = 1; src_en[2] = 1;
        run_drain();

        // R9: unlock with no lock held reserves nothing.
        clear_q(); rprob = 100; vprob = 100;
        add_pkt(1, 1, 1, 2); add_pkt(1, 2, 0, 0);
        add_pkt(0, 1, 2, 0); add_pkt(2, 1, 2, 0);
        src_en[0] = 0; src_en[2] = 0;
        step();
        src_en[0] = 1; src_en[2] = 1;
        run_drain();
        // R9: spare kind is also plain.
        clear_q();
        add_pkt(2, 1, 1, 3); add_pkt(2, 1, 0, 0);
        add_pkt(0, 1, 2, 0); add_pkt(1, 1, 2, 0);
        src_en[0] = 0; src_en[1] = 0;
        step();
        src_en[0] = 1; src_en[1] = 1;
        run_drain();

        // Random traffic with locks, gaps and stalls.
        for (int rnd = 0; rnd < 6 && !abort; rnd++) begin
            clear_q(); vprob = 75; rprob = 70;
            for (int i = 0; i < N; i++) begin
                while (q_cnt[i] < 40) begin
                    int r;
                    r = int'($urandom % 8);
                    if (r == 0 && q_cnt[i] <= 37) begin
                        add_pkt(i, 1 + int'($urandom % 4), int'($urandom % 4), 1);
                        add_pkt(i, 1 + int'($urandom % 4), int'($urandom % 4), 0);
                        add_pkt(i, 1 + int'($urandom % 4), int'($urandom % 4), 2);
                    end else begin
                        add_pkt(i, 1 + int'($urandom % 4), int'($urandom % 4),
                                (r == 1) ? 2 : (r == 2) ? 3 : 0);
                    end
                end
            end
            run_drain();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule